// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address onto a real page address through a small set of block translation entries, without touching any page table. Each entry is a pair of 32-bit words. The upper word names the block's effective base, a block-length mask and two validity bits, one for each privilege level. The lower word holds the real base and a two-bit protection code. Each block is naturally aligned, and its size runs from 128 KiB up to 256 MiB.

There are two separate entry arrays. Instruction fetches search one array and loads and stores search the other. A lookup presents the address, the access class and the privilege level. One clock later the block returns a hit flag, the 20-bit real page number and the read, write and execute rights. Software loads the entries through a single write port. That port carries the array select, the entry index, a word select and the data.

Top module: `bat_matcher`

## Requirements
- R1: A synchronous reset clears every entry in both arrays, so every lookup after reset misses, and it clears all outputs to zero.
- R2: A lookup with `lk_fetch`=1 searches only the instruction array. A lookup with `lk_fetch`=0 searches only the data array.
- R3: An entry takes part in a lookup only if it is valid for the current privilege. In supervisor mode (`lk_user`=0) upper bit 1 must be set. In user mode (`lk_user`=1) upper bit 0 must be set.
- R4: The block-length field sits in upper bits 12:2. A set bit k of that field removes effective-address bit 17+k from the compare, so the block can grow from 128 KiB to 256 MiB. Address bits 31:28 are always compared.
- R5: An entry hits when the effective address, ANDed with the compare mask over bits 31:17, equals upper bits 31:17 exactly. If the base has a bit set inside the masked-out range, the entry can never hit.
- R6: When several entries hit, the entry with the lowest index wins.
- R7: The real page number is built as follows. Masked address bits come from lower bits 31:17. The remaining bits of 31:12 come from the effective address. Bits 11:0 are dropped.
- R8: The protection code sits in lower bits 1:0. Code 0 grants nothing. Code 2 grants read, write and execute. Codes 1 and 3 grant read and execute. A hit is reported even when the code grants nothing.
- R9: On a miss, `out_hit` is 0 and the page and all rights are zero.
- R10: A lookup presented at a clock edge produces its result, with `out_valid`=1, after that same edge. `out_valid` is 0 one cycle after a clock with no lookup.
- R11: A write in the same cycle as a lookup does not affect that lookup. The written word takes effect from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the entry arrays |
| wr_fetch_arr | input | 1 | 1 selects the instruction array, 0 the data array |
| wr_idx | input | 2 | Entry index to write |
| wr_lower | input | 1 | 1 writes the lower word, 0 the upper word |
| wr_data | input | 32 | Word to write |
| lk_valid | input | 1 | Lookup request |
| lk_fetch | input | 1 | 1 for an instruction fetch, 0 for a load or store |
| lk_user | input | 1 | 1 for user privilege, 0 for supervisor |
| lk_ea | input | 32 | Effective address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_hit | output | 1 | An entry matched |
| out_page | output | 20 | Real page number (address bits 31:12) |
| out_rd | output | 1 | Read permitted |
| out_wr | output | 1 | Write permitted |
| out_ex | output | 1 | Execute permitted |

## Verification
A write to the entry arrays and a lookup can fall in the same clock. The lookup must see the arrays as they were before that edge.

The bench provokes this in two ways. First, a directed case invalidates the very entry a concurrent lookup needs, then repeats the lookup one cycle later. Second, the random phase mixes writes and lookups freely in the same cycles.

Each outcome is judged against a bench model. For each cycle, the model computes its expected result before it applies that cycle's write. As a result, a lookup that used the new word, or a write that was lost, shows up as a mismatch.

// File: rtl/bat_pkg.sv
package bat_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } bat_rights_t;

  // Two-bit protection code to access rights.
  function automatic bat_rights_t pp_decode(input logic [1:0] pp);
    bat_rights_t r;
    r = '0;
    if (pp != 2'd0) begin
      r.rd = 1'b1;
      r.ex = 1'b1;
      r.wr = (pp == 2'd2);
    end
    return r;
  endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
  parameter int ENTRIES = 4,
  parameter int AW      = 32,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_fetch_arr,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_lower,
  input  logic [AW-1:0] wr_data,
  input  logic          rd_fetch,
  output logic [AW-1:0] sel_upper [ENTRIES],
  output logic [AW-1:0] sel_lower [ENTRIES]
);

  logic [AW-1:0] upper_q [2][ENTRIES];
  logic [AW-1:0] lower_q [2][ENTRIES];

  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_fetch_arr == s[0]) && (wr_idx == IW'(e));

      always_ff @(posedge clk) begin
        if (rst) begin
          upper_q[s][e] <= '0;
          lower_q[s][e] <= '0;
        end else if (sel) begin
          if (wr_lower) lower_q[s][e] <= wr_data;
          else          upper_q[s][e] <= wr_data;
        end
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_rd
    assign sel_upper[e] = rd_fetch ? upper_q[1][e] : upper_q[0][e];
    assign sel_lower[e] = rd_fetch ? lower_q[1][e] : lower_q[0][e];
  end

endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
  import bat_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_LSB   = 17,
  parameter int BL_W      = 11,
  parameter int PAGE_BITS = 12,
  localparam int BLK_W    = AW - BLK_LSB,
  localparam int PW       = AW - PAGE_BITS
) (
  input  logic [AW-1:0] upper,
  input  logic [AW-1:0] lower,
  input  logic [AW-1:0] ea,
  input  logic          user,
  output logic          hit,
  output logic [PW-1:0] page,
  output bat_rights_t   rights
);

  logic [BLK_W-1:0] len_bits;
  logic [BLK_W-1:0] cmp_mask;
  logic [BLK_W-1:0] real_hi;
  logic             priv_ok;

  assign len_bits = {{(BLK_W-BL_W){1'b0}}, upper[BL_W+1:2]};
  assign cmp_mask = ~len_bits;
  assign priv_ok  = user ? upper[0] : upper[1];
  assign hit      = priv_ok &&
                    ((ea[AW-1:BLK_LSB] & cmp_mask) == upper[AW-1:BLK_LSB]);
  assign real_hi  = (lower[AW-1:BLK_LSB] & cmp_mask) |
                    (ea[AW-1:BLK_LSB] & ~cmp_mask);
  assign page     = {real_hi, ea[BLK_LSB-1:PAGE_BITS]};
  assign rights   = pp_decode(lower[1:0]);

endmodule

// File: rtl/bat_prio.sv
module bat_prio
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PW      = 20
) (
  input  logic [ENTRIES-1:0] hits,
  input  logic [PW-1:0]      pages  [ENTRIES],
  input  bat_rights_t        rights [ENTRIES],
  output logic               any_hit,
  output logic [PW-1:0]      win_page,
  output bat_rights_t        win_rights
);

  logic [ENTRIES-1:0] grant;

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    win_page   = '0;
    win_rights = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        win_page   = win_page | pages[i];
        win_rights = win_rights | rights[i];
      end
    end
  end

  assign any_hit = |hits;

  always_comb begin
    assert_grant_onehot_R6: assert ($onehot0(grant));
    assert_grant_in_hits_R6: assert ((grant & ~hits) == '0);
  end

endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int AW        = 32,
  parameter int BLK_LSB   = 17,
  parameter int BL_W      = 11,
  parameter int PAGE_BITS = 12,
  localparam int IW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PW       = AW - PAGE_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_fetch_arr,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_lower,
  input  logic [AW-1:0] wr_data,
  input  logic          lk_valid,
  input  logic          lk_fetch,
  input  logic          lk_user,
  input  logic [AW-1:0] lk_ea,
  output logic          out_valid,
  output logic          out_hit,
  output logic [PW-1:0] out_page,
  output logic          out_rd,
  output logic          out_wr,
  output logic          out_ex
);

  logic [AW-1:0]      ent_upper [ENTRIES];
  logic [AW-1:0]      ent_lower [ENTRIES];
  logic [ENTRIES-1:0] ent_hit;
  logic [PW-1:0]      ent_page  [ENTRIES];
  bat_rights_t        ent_rights [ENTRIES];
  logic               any_hit;
  logic [PW-1:0]      win_page;
  bat_rights_t        win_rights;

  bat_regfile #(.ENTRIES(ENTRIES), .AW(AW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_fetch_arr(wr_fetch_arr),
    .wr_idx      (wr_idx),
    .wr_lower    (wr_lower),
    .wr_data     (wr_data),
    .rd_fetch    (lk_fetch),
    .sel_upper   (ent_upper),
    .sel_lower   (ent_lower)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    bat_entry_cmp #(
      .AW(AW), .BLK_LSB(BLK_LSB), .BL_W(BL_W), .PAGE_BITS(PAGE_BITS)
    ) u_cmp (
      .upper (ent_upper[e]),
      .lower (ent_lower[e]),
      .ea    (lk_ea),
      .user  (lk_user),
      .hit   (ent_hit[e]),
      .page  (ent_page[e]),
      .rights(ent_rights[e])
    );
  end

  bat_prio #(.ENTRIES(ENTRIES), .PW(PW)) u_prio (
    .hits      (ent_hit),
    .pages     (ent_page),
    .rights    (ent_rights),
    .any_hit   (any_hit),
    .win_page  (win_page),
    .win_rights(win_rights)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_page  <= '0;
      out_rd    <= 1'b0;
      out_wr    <= 1'b0;
      out_ex    <= 1'b0;
    end else begin
      out_valid <= lk_valid;
      out_hit   <= lk_valid && any_hit;
      if (lk_valid && any_hit) begin
        out_page <= win_page;
        out_rd   <= win_rights.rd;
        out_wr   <= win_rights.wr;
        out_ex   <= win_rights.ex;
      end else begin
        out_page <= '0;
        out_rd   <= 1'b0;
        out_wr   <= 1'b0;
        out_ex   <= 1'b0;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_hit && out_page == '0));

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (!out_hit) |-> (out_page == '0 && !out_rd && !out_wr && !out_ex));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !out_valid);

  assert_write_implies_rx_R8: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> (out_rd && out_ex && out_hit));

  assert_page_offset_R7: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (out_page[BLK_LSB-PAGE_BITS-1:0] ==
                 $past(lk_ea[BLK_LSB-1:PAGE_BITS])));

endmodule

// File: tb/bat_matcher_tb.sv
module bat_matcher_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_fetch_arr, wr_lower;
  logic [1:0]  wr_idx;
  logic [31:0] wr_data;
  logic        lk_valid, lk_fetch, lk_user;
  logic [31:0] lk_ea;
  logic        out_valid, out_hit, out_rd, out_wr, out_ex;
  logic [19:0] out_page;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] m_up [2][4];
  logic [31:0] m_lo [2][4];

  always #4 clk = ~clk;

  bat_matcher u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fetch_arr(wr_fetch_arr),
    .wr_idx(wr_idx), .wr_lower(wr_lower), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_fetch(lk_fetch), .lk_user(lk_user), .lk_ea(lk_ea),
    .out_valid(out_valid), .out_hit(out_hit), .out_page(out_page),
    .out_rd(out_rd), .out_wr(out_wr), .out_ex(out_ex)
  );

  // {valid, hit, page[19:0], rd, wr, ex}
  function automatic logic [24:0] model(input logic f, input logic u, input logic [31:0] ea);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] up, lo, mask, ra;
      logic ok;
      up = m_up[f][i];
      lo = m_lo[f][i];
      ok = u ? up[0] : up[1];
      mask = 32'hFFFE_0000 & ~((up & 32'h0000_1FFC) << 15);
      if (ok && ((ea & mask) == (up & 32'hFFFE_0000))) begin
        ra = (lo & mask) | (ea & ~mask);
        case (lo[1:0])
          2'd0:    return {1'b1, 1'b1, ra[31:12], 3'b000};
          2'd2:    return {1'b1, 1'b1, ra[31:12], 3'b111};
          default: return {1'b1, 1'b1, ra[31:12], 3'b101};
        endcase
      end
    end
    return {1'b1, 24'd0};
  endfunction

  task automatic check(input string tag, input logic [24:0] exp);
    logic [24:0] act;
    act = {out_valid, out_hit, out_page, out_rd, out_wr, out_ex};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: optional write and optional lookup, checked one cycle later.
  task automatic cyc(input string tag,
                     input logic we, input logic wf, input logic [1:0] wi,
                     input logic wl, input logic [31:0] wd,
                     input logic lv, input logic lf, input logic lu,
                     input logic [31:0] ea);
    logic [24:0] exp;
    exp = lv ? model(lf, lu, ea) : 25'd0;
    if (we) begin
      if (wl) m_lo[wf][wi] = wd;
      else    m_up[wf][wi] = wd;
    end
    wr_en = we; wr_fetch_arr = wf; wr_idx = wi; wr_lower = wl; wr_data = wd;
    lk_valid = lv; lk_fetch = lf; lk_user = lu; lk_ea = ea;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    check(tag, exp);
  endtask

  task automatic wr(input logic f, input logic [1:0] i, input logic l, input logic [31:0] d);
    cyc("write", 1'b1, f, i, l, d, 1'b0, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic lk(input string tag, input logic f, input logic u, input logic [31:0] ea);
    cyc(tag, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0, 1'b1, f, u, ea);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++) begin m_up[s][i] = '0; m_lo[s][i] = '0; end
    rst = 1'b1; wr_en = 1'b0; wr_fetch_arr = 1'b0; wr_idx = '0; wr_lower = 1'b0;
    wr_data = '0; lk_valid = 1'b0; lk_fetch = 1'b0; lk_user = 1'b0; lk_ea = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset", 25'd0);
    rst = 1'b0;
    lk("R1 lookup after reset", 1'b0, 1'b0, 32'h0000_0000);
    lk("R1 lookup after reset", 1'b1, 1'b1, 32'h1234_5678);

    // data entry 0: base 0x1000_0000, 128 KiB, supervisor only, rwx
    wr(1'b0, 2'd0, 1'b0, 32'h1000_0002);
    wr(1'b0, 2'd0, 1'b1, 32'h8000_0002);
    lk("R5 R7 R8 basic hit", 1'b0, 1'b0, 32'h1001_2345);
    lk("R2 fetch uses other array", 1'b1, 1'b0, 32'h1001_2345);
    lk("R3 user needs bit 0", 1'b0, 1'b1, 32'h1001_2345);
    lk("R5 outside block", 1'b0, 1'b0, 32'h1002_0000);
    cyc("R10 idle cycle", 1'b0, 1'b0, 2'd0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 32'd0);

    // data entry 1: 256 MiB block at 0x2, user only, code 1
    wr(1'b0, 2'd1, 1'b0, 32'h2000_1FFD);
    wr(1'b0, 2'd1, 1'b1, 32'h4000_0001);
    lk("R4 R7 large block", 1'b0, 1'b1, 32'h2ABC_D123);
    lk("R3 supervisor needs bit 1", 1'b0, 1'b0, 32'h2ABC_D123);

    // entry 2 base bit inside mask: never hits
    wr(1'b0, 2'd2, 1'b0, 32'h3002_0006);
    wr(1'b0, 2'd2, 1'b1, 32'h5000_0003);
    lk("R5 dead base bit", 1'b0, 1'b0, 32'h3002_0000);
    // entries 2 and 3 overlap at 0x3: lowest wins
    wr(1'b0, 2'd2, 1'b0, 32'h3000_0FFE);
    wr(1'b0, 2'd3, 1'b0, 32'h3000_0002);
    wr(1'b0, 2'd3, 1'b1, 32'h6000_0002);
    lk("R6 lowest index wins, R8 code 3", 1'b0, 1'b0, 32'h3000_4000);

    // instruction entry 0: code 0
    wr(1'b1, 2'd0, 1'b0, 32'h1000_0003);
    wr(1'b1, 2'd0, 1'b1, 32'h9000_0000);
    lk("R8 code 0 hit no rights", 1'b1, 1'b1, 32'h1000_0FFF);
    lk("R2 data side unaffected", 1'b0, 1'b1, 32'h1000_0FFF);

    // same-cycle write and lookup
    cyc("R11 old contents used", 1'b1, 1'b0, 2'd0, 1'b0, 32'h0,
        1'b1, 1'b0, 1'b0, 32'h1000_1000);
    lk("R11 new contents next", 1'b0, 1'b0, 32'h1000_1000);
    lk("R9 miss zeros", 1'b0, 1'b0, 32'hF000_0000);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] up, lo, ea;
      logic [10:0] bl;
      bl = 11'($urandom) & (($urandom % 2) ? 11'h7FF : 11'h00F);
      up = {4'($urandom_range(1, 3)), 11'($urandom) & ~bl, 4'd0, bl, 2'($urandom)};
      lo = {20'($urandom), 10'd0, 2'($urandom)};
      ea = {4'($urandom_range(1, 3)), 28'($urandom)};
      cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random",
          ($urandom % 3) == 0, 1'($urandom), 2'($urandom), 1'($urandom),
          ($urandom % 2) ? up : lo,
          ($urandom % 4) != 0, 1'($urandom), 1'($urandom), ea);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule